// File: doc/BRIEF.md
# Accumulator ALU with Skip Conditions

This block is the 8-bit arithmetic and logic unit of an accumulator machine. It also holds the condition logic that decides whether the next instruction runs. Each cycle with `in_valid` high, it samples an operation code and its inputs:

- the accumulator;
- an operand, which is memory or immediate data chosen by the caller;
- the B register;
- a bit selector;
- the carry and half-carry flags.

One clock later it presents the result, the new carry and half-carry, and a skip flag.

Conditional operations never branch. When their condition is false they raise `skip_out`, and the sequencer then discards the next instruction. The two carry flags always travel as a pair. This lets the decimal adjust that follows an add or a subtract repair each nibble from its own carry.

Top module: `accum_alu_skip`

## Requirements
- R1: Results appear exactly one clock after the cycle in which `in_valid` was high, and `out_valid` marks them. After reset, all outputs are 0.
- R2: ADD (code 0) returns A+M modulo 256 and passes C and HC through unchanged. ADC (code 1) returns A+M+C, sets C to the carry out of bit 7 and sets HC to the carry out of bit 3.
- R3: SUBC (code 2) returns A+~M+C. C is 1 when no borrow occurs and HC is 1 when no borrow occurs out of bit 3.
- R4: AND (3), OR (4), XOR (5), INC (10), DEC (11) and CLR (12) compute their results modulo 256 and leave C and HC unchanged.
- R5: RRC (6) moves C into bit 7 and bit 0 into C. RLC (7) moves C into bit 0 and bit 7 into C. HC is unchanged by both.
- R6: SWAP (8) exchanges the two nibbles of A.
- R7: DCOR (9) subtracts 0x06 when HC is 0 and subtracts 0x60 when C is 0. Both flags are unchanged.
- R8: SC (13) sets both C and HC. RC (14) clears both C and HC.
- R9: IFEQ (16), IFNE (17) and IFGT (18, unsigned A>M) skip when their condition is false. The result is A.
- R10: ANDSZ (19) skips when A AND M is zero. The result is A.
- R11: IFBNE (20) skips when B[3:0] equals M[3:0]. The result is A.
- R12: DRSZ (21) returns M-1 and skips when that value is zero.
- R13: IFBIT (15) skips when bit `bit_sel` of M is 0. IFC (22) skips when C is 0. IFNC (23) skips when C is 1.
- R14: Non-conditional operations never skip. Codes 24 to 31 return A, pass both flags through and never skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_in | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator |
| opnd_in | input | 8 | Memory or immediate operand |
| b_in | input | 8 | B register |
| bit_sel | input | 3 | Bit number for IFBIT |
| c_in | input | 1 | Carry flag |
| hc_in | input | 1 | Half-carry flag |
| out_valid | output | 1 | Result valid |
| res_out | output | 8 | Result |
| c_out | output | 1 | New carry flag |
| hc_out | output | 1 | New half-carry flag |
| skip_out | output | 1 | Skip the next instruction |

## Verification
Operands are chosen so that carries leave bit 3 and bit 7 independently. This separates a half-carry taken from the wrong position from a full carry. Two-step BCD sequences are run: an add with the 0x66 bias followed by DCOR, and a subtract followed by DCOR. These show whether DCOR keys each nibble on the right flag. The compares use 0x80 against 0x7F, which catches a signed greater-than, and they use equal values, which catch an inverted skip sense. DRSZ runs with operands of 1, 0 and 0x10, which show the zero test and the wrap. IFBNE pairs B values that differ only in their upper nibble, which shows that only the lower nibble is compared.

// File: rtl/alu_skip_pkg.sv
package alu_skip_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUBC  = 5'd2,
        OP_AND   = 5'd3,
        OP_OR    = 5'd4,
        OP_XOR   = 5'd5,
        OP_RRC   = 5'd6,
        OP_RLC   = 5'd7,
        OP_SWAP  = 5'd8,
        OP_DCOR  = 5'd9,
        OP_INC   = 5'd10,
        OP_DEC   = 5'd11,
        OP_CLR   = 5'd12,
        OP_SETC  = 5'd13,
        OP_CLRC  = 5'd14,
        OP_TBIT  = 5'd15,
        OP_CEQ   = 5'd16,
        OP_CNE   = 5'd17,
        OP_CGT   = 5'd18,
        OP_ANDZ  = 5'd19,
        OP_BNE4  = 5'd20,
        OP_DECZ  = 5'd21,
        OP_TC    = 5'd22,
        OP_TNC   = 5'd23
    } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_skip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              c_in,
    input  logic              hc_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              hc_out
);
    localparam int NIB_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(6);
    localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6) << NIB_W;

    logic              is_sub;
    logic              add_cin;
    logic [DATA_W-1:0] m_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    half_sum;

    // One adder serves ADD, ADC and SUBC; subtraction inverts the operand.
    always_comb begin
        is_sub   = (op == OP_SUBC);
        add_cin  = (op == OP_ADD) ? 1'b0 : c_in;
        m_eff    = is_sub ? ~m : m;
        full_sum = {1'b0, a} + {1'b0, m_eff} + {{DATA_W{1'b0}}, add_cin};
        half_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, m_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, add_cin};
    end

    always_comb begin
        res    = a;
        c_out  = c_in;
        hc_out = hc_in;
        unique case (op)
            OP_ADD:  res = full_sum[DATA_W-1:0];
            OP_ADC, OP_SUBC: begin
                res    = full_sum[DATA_W-1:0];
                c_out  = full_sum[DATA_W];
                hc_out = half_sum[NIB_W];
            end
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_RRC: begin
                res   = {c_in, a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_RLC: begin
                res   = {a[DATA_W-2:0], c_in};
                c_out = a[DATA_W-1];
            end
            OP_SWAP: res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
            OP_DCOR: res = a - (hc_in ? '0 : LO_FIX) - (c_in ? '0 : HI_FIX);
            OP_INC:  res = a + 1'b1;
            OP_DEC:  res = a - 1'b1;
            OP_CLR:  res = '0;
            OP_SETC: begin
                c_out  = 1'b1;
                hc_out = 1'b1;
            end
            OP_CLRC: begin
                c_out  = 1'b0;
                hc_out = 1'b0;
            end
            OP_DECZ: res = m - 1'b1;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_skip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e                      op,
    input  logic [DATA_W-1:0]            a,
    input  logic [DATA_W-1:0]            m,
    input  logic [DATA_W/2-1:0]          b_lo,
    input  logic [$clog2(DATA_W)-1:0]    bit_sel,
    input  logic                         c_in,
    output logic                         skip
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W-1:0] m_dec;
    assign m_dec = m - 1'b1;

    // A true condition runs the next instruction; a false one skips it.
    always_comb begin
        unique case (op)
            OP_CEQ:  skip = (a != m);
            OP_CNE:  skip = (a == m);
            OP_CGT:  skip = !(a > m);
            OP_ANDZ: skip = ((a & m) == '0);
            OP_BNE4: skip = (b_lo == m[NIB_W-1:0]);
            OP_DECZ: skip = (m_dec == '0);
            OP_TBIT: skip = !m[bit_sel];
            OP_TC:   skip = !c_in;
            OP_TNC:  skip = c_in;
            default: skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/accum_alu_skip.sv
module accum_alu_skip
    import alu_skip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [OP_W-1:0]           op_in,
    input  logic [DATA_W-1:0]         acc_in,
    input  logic [DATA_W-1:0]         opnd_in,
    input  logic [DATA_W-1:0]         b_in,
    input  logic [$clog2(DATA_W)-1:0] bit_sel,
    input  logic                      c_in,
    input  logic                      hc_in,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         res_out,
    output logic                      c_out,
    output logic                      hc_out,
    output logic                      skip_out
);
    localparam int NIB_W = DATA_W / 2;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              c;
        logic              hc;
        logic              skip;
    } stage_t;

    stage_t            st_d, st_q;
    alu_op_e           op_e;
    logic [DATA_W-1:0] ar_res;
    logic              ar_c, ar_hc, cd_skip;

    assign op_e = alu_op_e'(op_in);

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op     (op_e),
        .a      (acc_in),
        .m      (opnd_in),
        .c_in   (c_in),
        .hc_in  (hc_in),
        .res    (ar_res),
        .c_out  (ar_c),
        .hc_out (ar_hc)
    );

    alu_cond #(.DATA_W(DATA_W)) u_cond (
        .op      (op_e),
        .a       (acc_in),
        .m       (opnd_in),
        .b_lo    (b_in[NIB_W-1:0]),
        .bit_sel (bit_sel),
        .c_in    (c_in),
        .skip    (cd_skip)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res  = ar_res;
            st_d.c    = ar_c;
            st_d.hc   = ar_hc;
            st_d.skip = cd_skip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_out   = st_q.res;
    assign c_out     = st_q.c;
    assign hc_out    = st_q.hc;
    assign skip_out  = st_q.skip;

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    setc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in == OP_SETC) |=> (c_out && hc_out));

    // R4
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_in == OP_AND || op_in == OP_OR || op_in == OP_XOR ||
                      op_in == OP_INC || op_in == OP_DEC))
        |=> (c_out == $past(c_in) && hc_out == $past(hc_in)));

    // R14
    noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in <= OP_CLRC) |=> !skip_out);

    // R9
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_in == OP_CEQ || op_in == OP_CNE || op_in == OP_CGT))
        |=> (res_out == $past(acc_in)));

    // R6
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in == OP_SWAP)
        |=> (res_out[NIB_W-1:0] == $past(acc_in[DATA_W-1:NIB_W])));
endmodule

// File: tb/accum_alu_skip_tb.sv
module accum_alu_skip_tb;
    typedef struct {
        logic [7:0] res;
        logic       c;
        logic       hc;
        logic       skip;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op_in = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
    logic [2:0] bit_sel = '0;
    logic       c_in = 1'b0, hc_in = 1'b0;
    logic       out_valid, c_out, hc_out, skip_out;
    logic [7:0] res_out;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    accum_alu_skip u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
        .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in), .bit_sel(bit_sel),
        .c_in(c_in), .hc_in(hc_in), .out_valid(out_valid), .res_out(res_out),
        .c_out(c_out), .hc_out(hc_out), .skip_out(skip_out)
    );

    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] b, input logic [2:0] bs, input logic c,
                         input logic hc, input logic [7:0] e_res, input logic e_c,
                         input logic e_hc, input logic e_skip, input string tag);
        exp_t e;
        op_in = op; acc_in = a; opnd_in = m; b_in = b; bit_sel = bs;
        c_in = c; hc_in = hc; in_valid = 1'b1;
        e.res = e_res; e.c = e_c; e.hc = e_hc; e.skip = e_skip; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: outputs were registered at the previous rising edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected result res=%h expected none", res_out);
            end else begin
                e = sb_q.pop_front();
                if (res_out !== e.res || c_out !== e.c || hc_out !== e.hc || skip_out !== e.skip) begin
                    n_bad++;
                    $display("FAIL %s res/c/hc/skip actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                             e.tag, res_out, c_out, hc_out, skip_out, e.res, e.c, e.hc, e.skip);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || res_out !== 8'h00 || c_out !== 1'b0 || hc_out !== 1'b0 || skip_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset state actual=%b/%h/%b/%b/%b expected=0/00/0/0/0",
                     out_valid, res_out, c_out, hc_out, skip_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: biased BCD add, then R7 correction
        drive(5'd0,  8'h38, 8'h66, 8'h00, 3'd0, 1'b0, 1'b1, 8'h9E, 1'b0, 1'b1, 1'b0, "R2 add");
        drive(5'd1,  8'h9E, 8'h45, 8'h00, 3'd0, 1'b0, 1'b1, 8'hE3, 1'b0, 1'b1, 1'b0, "R2 adc");
        drive(5'd1,  8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R2 adc wrap");
        drive(5'd9,  8'hE3, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 8'h83, 1'b0, 1'b1, 1'b0, "R7 dcor add");
        // R3 and R7 after a subtract
        drive(5'd2,  8'h42, 8'h15, 8'h00, 3'd0, 1'b1, 1'b0, 8'h2D, 1'b1, 1'b0, 1'b0, "R3 subc");
        drive(5'd9,  8'h2D, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h27, 1'b1, 1'b0, 1'b0, "R7 dcor sub");
        drive(5'd2,  8'h10, 8'h20, 8'h00, 3'd0, 1'b1, 1'b0, 8'hF0, 1'b0, 1'b1, 1'b0, "R3 subc borrow");
        // R4
        drive(5'd3,  8'hF0, 8'h3C, 8'h00, 3'd0, 1'b1, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0, "R4 and");
        drive(5'd4,  8'hF0, 8'h0F, 8'h00, 3'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, "R4 or");
        drive(5'd5,  8'hAA, 8'hFF, 8'h00, 3'd0, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0, "R4 xor");
        drive(5'd10, 8'hFF, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R4 inc");
        drive(5'd11, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, "R4 dec");
        drive(5'd12, 8'h5A, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4 clr");
        // R5
        drive(5'd6,  8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 8'h40, 1'b1, 1'b1, 1'b0, "R5 rrc");
        drive(5'd6,  8'h02, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, "R5 rrc c in");
        drive(5'd7,  8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, "R5 rlc");
        // R6, R8
        drive(5'd8,  8'h3C, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0, "R6 swap");
        drive(5'd13, 8'h12, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'h12, 1'b1, 1'b1, 1'b0, "R8 sc");
        drive(5'd14, 8'h12, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 8'h12, 1'b0, 1'b0, 1'b0, "R8 rc");
        // R9
        drive(5'd16, 8'h55, 8'h55, 8'h00, 3'd0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, "R9 ifeq true");
        drive(5'd16, 8'h55, 8'h54, 8'h00, 3'd0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, "R9 ifeq false");
        drive(5'd17, 8'h55, 8'h55, 8'h00, 3'd0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, "R9 ifne false");
        drive(5'd18, 8'h80, 8'h7F, 8'h00, 3'd0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, "R9 ifgt unsigned");
        drive(5'd18, 8'h7F, 8'h7F, 8'h00, 3'd0, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0, 1'b1, "R9 ifgt equal");
        // R10, R11
        drive(5'd19, 8'hF0, 8'h0F, 8'h00, 3'd0, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b1, "R10 andsz zero");
        drive(5'd19, 8'hF0, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0, "R10 andsz nonzero");
        drive(5'd20, 8'h11, 8'h05, 8'hA5, 3'd0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b1, "R11 ifbne equal");
        drive(5'd20, 8'h11, 8'h06, 8'hA5, 3'd0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, "R11 ifbne differ");
        // R12
        drive(5'd21, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R12 drsz zero");
        drive(5'd21, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, "R12 drsz wrap");
        drive(5'd21, 8'h00, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0, 8'h0F, 1'b1, 1'b0, 1'b0, "R12 drsz nonzero");
        // R13
        drive(5'd15, 8'h00, 8'h08, 8'h00, 3'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R13 ifbit set");
        drive(5'd15, 8'h00, 8'h08, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R13 ifbit clear");
        drive(5'd22, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R13 ifc");
        drive(5'd23, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R13 ifnc");
        // R14
        drive(5'd25, 8'h77, 8'h12, 8'h00, 3'd0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0, 1'b0, "R14 unused code");

        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 idle actual valid=%b pending=%0d expected valid=0 pending=0",
                     out_valid, sb_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule